// File: doc/BRIEF.md
# UART Data Buffer and Status Unit

This block is the buffering layer between a CPU register bus and a pair of serial shifters. A single data address serves both directions. A bus write loads a one-entry transmit holding register, and a bus read pops the oldest character from a two-entry receive queue. The two storages are separate. A second address holds the status byte. It carries the flags software polls or takes interrupts from, and the per-character error bits of the character at the head of the queue. Software reads status before it reads data.

Characters move to and from the shifters over valid/ready streams. On the transmit stream, `tx_valid` is high only while a character is held and the transmitter is enabled. The character leaves the holding register on the first edge where `tx_ready` is also high. The shifter holds `tx_ready` low while it is busy. On the receive stream, `rx_ready` follows the receiver enable. The block never stalls the receive shifter. When the queue is full, an arriving character is discarded and recorded as an overflow. Character lengths of 5 to 9 bits are selected on `char_len`. Bits above the selected length are cleared on both paths.

Top module: `uart_buf_top`

## Requirements
- R1: A write to the data address (`addr`=0) loads the transmit holding register. A read of the data address returns bits 7:0 of the receive queue head, or 0 when the queue is empty. The two storages never affect each other.
- R2: The receive queue holds two characters and returns them in arrival order. Status bit 4 (frame error), bit 2 (parity error) and bit 0 (ninth data bit) belong to the current head character. They advance when the head is popped by a data read.
- R3: For `char_len` 5 to 8, data bits at and above position `char_len` are forced to zero on `tx_data` and in received characters. A value of 9 keeps all nine bits. The ninth transmit bit comes from `tx_bit8` at the time of the data write.
- R4: A data write while status bit 5 (data-register-empty) is 0 is discarded and leaves the held character unchanged.
- R5: `tx_valid` is `tx_en` AND (a character is held). On an edge with `tx_valid` and `tx_ready` both high, the holding register empties and status bit 5 returns to 1.
- R6: After reset the status byte (`addr`=1) reads 0x20.
- R7: Status bit 7 is 1 exactly when the receive queue is non-empty. While `rx_en` is 0 the queue is flushed, so bit 7 reads 0 after one clock.
- R8: Status bit 6 sets on a `tx_done` pulse while no character is held. It clears on `txc_ack`, or on a status write with bit 6 set. A `tx_done` pulse while a character is held leaves it unchanged.
- R9: A character that arrives while the queue holds two entries and no pop occurs is dropped. Status bit 3 then reads 1 until the next data read pops the head.
- R10: A status write with bit 7 set flushes the receive queue. Written values of bits 5, 4, 3, 2 and 0 have no effect.
- R11: `rx_ready` equals `rx_en`. Every offered character is taken while the receiver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the queue |
| char_len | input | 4 | Character length, 5 to 9 |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (pops on data address) |
| addr | input | 1 | 0 = data, 1 = status |
| wdata | input | 8 | Bus write data |
| tx_bit8 | input | 1 | Ninth bit for a data write |
| rdata | output | 8 | Bus read data for `addr` |
| tx_valid | output | 1 | Transmit stream valid |
| tx_ready | input | 1 | Transmit shifter idle |
| tx_data | output | 9 | Character to the transmit shifter |
| tx_done | input | 1 | Pulse: shifter finished a frame |
| txc_ack | input | 1 | Transmit-complete acknowledge |
| rx_valid | input | 1 | Receive stream valid |
| rx_ready | output | 1 | Receive stream ready |
| rx_data | input | 9 | Received character |
| rx_ferr | input | 1 | Frame error of received character |
| rx_perr | input | 1 | Parity error of received character |

## Verification
The hardest state to reach is a full queue that receives a third character. The overflow mark must then be shown with the head character and must disappear on the next pop, not on a status read. The bench pushes three characters back to back with no reads in between. It reads status, pops, and reads status again, and checks that bit 3 clears while the two kept characters come out in order. A second hard case is a dropped data write while a character is held. The bench parks the transmitter disabled, writes twice, and only then enables it, so the character handed over shows which write survived.

// File: rtl/uart_buf_pkg.sv
package uart_buf_pkg;
  localparam int CHAR_MAX = 9;

  typedef struct packed {
    logic                ferr;
    logic                perr;
    logic [CHAR_MAX-1:0] data;
  } rx_ent_t;

  // Clear bits at and above the selected length (clamped to 5..CHAR_MAX).
  function automatic logic [CHAR_MAX-1:0] char_mask(logic [CHAR_MAX-1:0] d,
                                                    logic [3:0] len);
    int n;
    logic [CHAR_MAX-1:0] m;
    n = int'(len);
    if (n < 5) n = 5;
    if (n > CHAR_MAX) n = CHAR_MAX;
    for (int i = 0; i < CHAR_MAX; i++) m[i] = (i < n);
    return d & m;
  endfunction
endpackage

// File: rtl/uart_txbuf.sv
module uart_txbuf #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tx_en,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         full
);
  logic [W-1:0] hold_q;
  logic         full_q;
  logic         take;

  assign tx_valid = full_q && tx_en;
  assign take     = tx_valid && tx_ready;
  assign tx_data  = hold_q;
  assign full     = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (load && !full_q) begin
      hold_q <= load_data;
      full_q <= 1'b1;
    end
  end

  // R4: a write while holding a character leaves it untouched
  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && load && !take) |=> (full_q && $stable(hold_q)));

  // R5: handoff empties the holding register
  p_handoff_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !full_q);
endmodule

// File: rtl/uart_rxfifo.sv
module uart_rxfifo
  import uart_buf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    push,
  input  rx_ent_t push_ent,
  input  logic    pop,
  output rx_ent_t head,
  output logic    not_empty,
  output logic    ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_ent_t       mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_pop, do_push, drop;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop    = pop && (count != '0);
  assign do_push   = push && ((count != FULL_CNT) || do_pop);
  assign drop      = push && !do_push;
  assign not_empty = (count != '0);
  assign head      = not_empty ? mem[rptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (drop)        ovf <= 1'b1;
      else if (do_pop) ovf <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[g] <= '0;
        else if (!flush && do_push && (wptr == PW'(g))) mem[g] <= push_ent;
      end
    end
  endgenerate

  // R2: occupancy never exceeds the queue depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R7: a flush leaves the queue empty
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !not_empty);

  // R9: arrival into a full queue with no pop marks overflow
  p_overflow_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && count == FULL_CNT && !pop) |=> (ovf && count == FULL_CNT));
endmodule

// File: rtl/uart_buf_top.sv
module uart_buf_top
  import uart_buf_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                rx_en,
  input  logic [3:0]          char_len,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic                addr,
  input  logic [7:0]          wdata,
  input  logic                tx_bit8,
  output logic [7:0]          rdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [CHAR_MAX-1:0] tx_data,
  input  logic                tx_done,
  input  logic                txc_ack,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [CHAR_MAX-1:0] rx_data,
  input  logic                rx_ferr,
  input  logic                rx_perr
);
  logic    data_wr, stat_wr, data_rd;
  logic    txb_full, txc_q, rx_ne, rx_ovf, rx_flush;
  rx_ent_t in_ent, head;
  logic [7:0] status;

  assign data_wr  = wr_en && !addr;
  assign stat_wr  = wr_en && addr;
  assign data_rd  = rd_en && !addr;
  assign rx_ready = rx_en;
  assign rx_flush = !rx_en || (stat_wr && wdata[7]);

  assign in_ent.ferr = rx_ferr;
  assign in_ent.perr = rx_perr;
  assign in_ent.data = char_mask(rx_data, char_len);

  uart_txbuf #(.W(CHAR_MAX)) i_txbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_wr),
    .load_data (char_mask({tx_bit8, wdata}, char_len)),
    .tx_en     (tx_en),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .full      (txb_full)
  );

  uart_rxfifo #(.DEPTH(RX_DEPTH)) i_rxfifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rx_valid && rx_ready),
    .push_ent  (in_ent),
    .pop       (data_rd),
    .head      (head),
    .not_empty (rx_ne),
    .ovf       (rx_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            txc_q <= 1'b0;
    else if (tx_done && !txb_full)         txc_q <= 1'b1;
    else if (txc_ack || (stat_wr && wdata[6])) txc_q <= 1'b0;
  end

  assign status = {rx_ne, txc_q, !txb_full, head.ferr, rx_ovf, head.perr,
                   1'b0, head.data[8]};
  assign rdata  = addr ? status : head.data[7:0];

  // R8: finishing a frame with nothing held flags transmit-complete
  p_txc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !txb_full) |=> txc_q);

  // R8: acknowledge without a new completion clears the flag
  p_txc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_ack && !tx_done) |=> !txc_q);

  // R7: receive-complete drops one clock after the receiver is disabled
  p_rx_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !status[7]);
endmodule

// File: tb/test_uart_buf_top.sv
module test_uart_buf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b1;
  logic [3:0] char_len = 4'd8;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic       tx_bit8 = 1'b0;
  logic [7:0] rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [8:0] tx_data;
  logic       tx_done = 1'b0, txc_ack = 1'b0;
  logic       rx_valid = 1'b0, rx_ready;
  logic [8:0] rx_data = '0;
  logic       rx_ferr = 1'b0, rx_perr = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_buf_top i_uart_buf_top (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .char_len(char_len), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tx_bit8(tx_bit8), .rdata(rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_done(tx_done),
    .txc_ack(txc_ack), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic a, logic [7:0] d, logic b8);
    @(negedge clk);
    addr = a; wdata = d; tx_bit8 = b8; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_status(output logic [7:0] v);
    @(negedge clk);
    addr = 1'b1;
    #1 v = rdata;
  endtask

  task automatic pop_data(output logic [7:0] v);
    @(negedge clk);
    addr = 1'b0; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rx_push(logic [8:0] d, logic fe, logic pe);
    @(negedge clk);
    rx_data = d; rx_ferr = fe; rx_perr = pe; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_ferr = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    read_status(s);
    check("R6 reset status", s, 8'h20);
    check("R5 no tx_valid after reset", tx_valid, 1'b0);
    check("R11 rx_ready follows rx_en", rx_ready, 1'b1);
  endtask

  task automatic t_tx_path();
    logic [7:0] s;
    char_len = 4'd8;
    bus_write(1'b0, 8'hA5, 1'b0);
    read_status(s);
    check("R1 data write fills buffer (DRE=0)", s, 8'h00);
    bus_write(1'b0, 8'h3C, 1'b0);
    check("R5 tx_valid low while tx_en low", tx_valid, 1'b0);
    @(negedge clk); tx_en = 1'b1;
    #1 check("R5 tx_valid with tx_en", tx_valid, 1'b1);
    check("R4 dropped write leaves held char", tx_data, 9'h0A5);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    read_status(s);
    check("R5 handoff restores DRE", s, 8'h20);
    check("R5 tx_valid low after handoff", tx_valid, 1'b0);
  endtask

  task automatic t_mask();
    logic [7:0] v, s;
    tx_en = 1'b0;
    char_len = 4'd5;
    bus_write(1'b0, 8'hFF, 1'b1);
    #1 check("R3 tx 5-bit mask", tx_data, 9'h01F);
    tx_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0; tx_en = 1'b0;
    rx_push(9'h1FF, 1'b0, 1'b0);
    read_status(s);
    check("R3 rx 5-bit ninth bit cleared", s, 8'hA0);
    pop_data(v);
    check("R3 rx 5-bit data masked", v, 8'h1F);
    char_len = 4'd9;
    bus_write(1'b0, 8'h12, 1'b1);
    #1 check("R3 tx 9-bit keeps bit8", tx_data, 9'h112);
    tx_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0; tx_en = 1'b0;
  endtask

  task automatic t_txc();
    logic [7:0] s;
    pulse_done();
    read_status(s);
    check("R8 txc set on done", s, 8'h60);
    bus_write(1'b1, 8'h40, 1'b0);
    read_status(s);
    check("R8 txc cleared by writing one", s, 8'h20);
    pulse_done();
    @(negedge clk); txc_ack = 1'b1;
    @(negedge clk); txc_ack = 1'b0;
    read_status(s);
    check("R8 txc cleared by ack", s, 8'h20);
    bus_write(1'b0, 8'h01, 1'b0);
    pulse_done();
    read_status(s);
    check("R8 no txc while char held", s, 8'h00);
    tx_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0; tx_en = 1'b0;
  endtask

  task automatic t_rx_order();
    logic [7:0] v, s;
    char_len = 4'd9;
    rx_push(9'h155, 1'b1, 1'b0);
    rx_push(9'h0AA, 1'b0, 1'b1);
    read_status(s);
    check("R2 head status ferr/bit8", s, 8'hB1);
    pop_data(v);
    check("R2 first char", v, 8'h55);
    read_status(s);
    check("R2 status advances to perr", s, 8'hA4);
    pop_data(v);
    check("R2 second char", v, 8'hAA);
    read_status(s);
    check("R7 rxc clear when empty", s, 8'h20);
    pop_data(v);
    check("R1 empty read returns zero", v, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] v, s;
    char_len = 4'd8;
    rx_push(9'h011, 1'b0, 1'b0);
    rx_push(9'h022, 1'b0, 1'b0);
    rx_push(9'h033, 1'b0, 1'b0);
    read_status(s);
    check("R9 overflow flagged", s, 8'hA8);
    read_status(s);
    check("R9 status read keeps overflow", s, 8'hA8);
    pop_data(v);
    check("R9 oldest kept", v, 8'h11);
    read_status(s);
    check("R9 overflow cleared by pop", s, 8'hA0);
    pop_data(v);
    check("R9 second kept, third dropped", v, 8'h22);
    read_status(s);
    check("R9 queue empty after two pops", s, 8'h20);
  endtask

  task automatic t_flush();
    logic [7:0] s;
    rx_push(9'h044, 1'b1, 1'b1);
    @(negedge clk); rx_en = 1'b0;
    #1 check("R11 rx_ready low when disabled", rx_ready, 1'b0);
    rx_data = 9'h077; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    read_status(s);
    check("R7 disable flushes queue", s, 8'h20);
    rx_en = 1'b1;
    read_status(s);
    check("R11 no char taken while disabled", s, 8'h20);
  endtask

  task automatic t_status_write();
    logic [7:0] s;
    rx_push(9'h055, 1'b0, 1'b0);
    bus_write(1'b1, 8'h80, 1'b0);
    read_status(s);
    check("R10 writing one to bit7 flushes", s, 8'h20);
    bus_write(1'b0, 8'h09, 1'b0);
    bus_write(1'b1, 8'h3D, 1'b0);
    read_status(s);
    check("R10 DRE/error bits not writable", s, 8'h00);
    check("R1 status write leaves tx char", tx_data, 9'h009);
    tx_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0; tx_en = 1'b0;
    read_status(s);
    check("R5 buffer empties after handoff", s, 8'h20);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_path();
    t_mask();
    t_txc();
    t_rx_order();
    t_overflow();
    t_flush();
    t_status_write();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule